// File: doc/BRIEF.md
# Four-Channel Stepped-Frequency PWM Generator

This block drives four independent pulse-width-modulated outputs from settings held in a register file elsewhere. Each channel has four settings. An 8-bit frequency code holds a 2-bit step selector and a 6-bit multiplier. An 8-bit duty code sets the active fraction. One bit inverts the waveform, and one bit enables the channel.

The output frequency is the multiplier plus one, times a base rate. The base rate grows fourfold with each step code: 0.5 Hz, 2 Hz, 8 Hz and 32 Hz. Each channel builds its waveform with a phase accumulator. The accumulator advances on a shared timebase tick, which a prescaler derives from the clock.

Settings are not double-buffered. A new frequency, duty or polarity value acts on the next cycle, and the accumulator keeps running. A global mode input holds every output low until it carries the normal-operation value.

Each channel runs a two-state machine:
- `CH_IDLE`: phase held at zero, output low.
- `CH_RUN`: phase advancing, output follows the comparison.

The transitions are:
- `start`: `CH_IDLE` to `CH_RUN` when the channel is enabled and the mode is normal.
- `stop`: `CH_RUN` to `CH_IDLE` when either condition is lost.

In every other case the machine stays in its current state.

Top module: `quad_step_pwm`

## Requirements
- R1: While `rst` is high, every output is low after the next clock edge. After reset, all phases are zero and all channels are in `CH_IDLE`.
- R2: In a frequency code, bits 7:6 are the step and bits 5:0 are the count. In `CH_RUN`, each timebase tick adds (count+1) shifted left by 2×step to a PHASE_W-bit phase, which wraps modulo 2^PHASE_W. An increment of 1 therefore corresponds to 0.5 Hz.
- R3: A running channel is active while the top 8 bits of its phase are less than or equal to its duty code. A code of 255 is active all the time. A code of 0 is active for 1/256 of the period, so no code gives 0 %.
- R4: With the channel's invert bit at 1, a running channel drives the complement of the R3 active level.
- R5: A channel that is disabled drives low whatever its invert bit is. It re-enters `CH_RUN` with its phase at zero.
- R6: Unless `mode_sel` equals NORMAL_MODE (default 2'b01), every channel goes to `CH_IDLE` and drives low.
- R7: A change to frequency, duty or invert on a running channel acts from the next cycle, and the phase is not reset.
- R8: Every output comes from a register. The output after clock edge n reflects the state, phase and settings held just before edge n.
- R9: The four channels are independent. Settings on one channel never change another channel's output.
- R10: The timebase tick occurs on one clock in every TICK_DIV. The phase changes only on tick cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 2 | Global operating mode; outputs run only at NORMAL_MODE |
| freq_code | input | 8×NUM_CH | Frequency codes, channel k at bits [8k+7:8k] |
| duty_code | input | 8×NUM_CH | Duty codes, channel k at bits [8k+7:8k] |
| pol_inv | input | NUM_CH | Invert bit per channel |
| ch_en | input | NUM_CH | Enable bit per channel |
| pwm_out | output | NUM_CH | Registered PWM outputs |

## Verification
The bench builds the block with PHASE_W = 14 and TICK_DIV = 3.

The narrow phase puts several full periods within a few thousand cycles, using the fastest codes (step 3, count 63). A divider of 3 makes the prescaler visible: the phase must hold for two clocks out of every three.

The slowest code (step 0, count 0) still reaches its first compare transition quickly. That lets the bench see the 1/256 duty floor.

// File: rtl/quad_step_pwm_pkg.sv
package quad_step_pwm_pkg;

    // Widest phase increment: (63+1) << 6 needs 13 bits
    localparam int INC_W = 13;

    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_e;

    // Phase increment from a frequency code: (count+1) << (2*step)
    function automatic logic [INC_W-1:0] step_increment(input logic [7:0] code);
        logic [INC_W-1:0] mult;
        mult = INC_W'({1'b0, code[5:0]}) + INC_W'(1);
        return mult << (2 * code[7:6]);
    endfunction

endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
    parameter int TICK_DIV = 1
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    generate
        if (TICK_DIV <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            logic [CW-1:0] cnt_q;
            always_ff @(posedge clk) begin
                if (rst)
                    cnt_q <= '0;
                else if (cnt_q == LAST)
                    cnt_q <= '0;
                else
                    cnt_q <= cnt_q + CW'(1);
            end
            assign tick = (cnt_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import quad_step_pwm_pkg::*;
#(
    parameter int PHASE_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               go,
    input  logic [7:0]         freq,
    input  logic [7:0]         duty,
    input  logic               inv,
    output logic               pwm_o,
    output logic               run_o,
    output logic [PHASE_W-1:0] phase_o
);
    ch_state_e state_q, state_d;
    logic [PHASE_W-1:0] phase_q;
    logic [PHASE_W-1:0] inc;
    logic [7:0]         phase_top;
    logic               active;

    assign inc       = PHASE_W'(step_increment(freq));
    assign phase_top = phase_q[PHASE_W-1 -: 8];
    assign active    = (phase_top <= duty);

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= CH_IDLE;
        else     state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: if (go)  state_d = CH_RUN;   // start
            CH_RUN:  if (!go) state_d = CH_IDLE;  // stop
        endcase
    end

    // phase accumulator
    always_ff @(posedge clk) begin
        if (rst || state_q == CH_IDLE)
            phase_q <= '0;
        else if (tick)
            phase_q <= phase_q + inc;
    end

    // registered output
    always_ff @(posedge clk) begin
        if (rst) begin
            pwm_o <= 1'b0;
        end else begin
            unique case (state_q)
                CH_IDLE: pwm_o <= 1'b0;
                CH_RUN:  pwm_o <= active ^ inv;
            endcase
        end
    end

    assign run_o   = (state_q == CH_RUN);
    assign phase_o = phase_q;
endmodule

// File: rtl/quad_step_pwm.sv
module quad_step_pwm
    import quad_step_pwm_pkg::*;
#(
    parameter int          NUM_CH      = 4,
    parameter int          PHASE_W     = 16,
    parameter int          TICK_DIV    = 1,
    parameter logic [1:0]  NORMAL_MODE = 2'b01
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [1:0]            mode_sel,
    input  logic [8*NUM_CH-1:0]   freq_code,
    input  logic [8*NUM_CH-1:0]   duty_code,
    input  logic [NUM_CH-1:0]     pol_inv,
    input  logic [NUM_CH-1:0]     ch_en,
    output logic [NUM_CH-1:0]     pwm_out
);
    logic                        tick_w;
    logic                        mode_ok;
    logic [NUM_CH-1:0]           run_vec;
    logic [NUM_CH*PHASE_W-1:0]   phase_flat;

    assign mode_ok = (mode_sel == NORMAL_MODE);

    pwm_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick_w)
    );

    generate
        for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
            pwm_channel #(.PHASE_W(PHASE_W)) u_ch (
                .clk     (clk),
                .rst     (rst),
                .tick    (tick_w),
                .go      (ch_en[k] && mode_ok),
                .freq    (freq_code[8*k +: 8]),
                .duty    (duty_code[8*k +: 8]),
                .inv     (pol_inv[k]),
                .pwm_o   (pwm_out[k]),
                .run_o   (run_vec[k]),
                .phase_o (phase_flat[PHASE_W*k +: PHASE_W])
            );
        end
    endgenerate
endmodule

// File: rtl/quad_step_pwm_chk.sv
module quad_step_pwm_chk #(
    parameter int         NUM_CH      = 4,
    parameter int         PHASE_W     = 16,
    parameter logic [1:0] NORMAL_MODE = 2'b01
) (
    input logic                      clk,
    input logic                      rst,
    input logic [1:0]                mode_sel,
    input logic [8*NUM_CH-1:0]       duty_code,
    input logic [NUM_CH-1:0]         pol_inv,
    input logic [NUM_CH-1:0]         ch_en,
    input logic                      tick,
    input logic [NUM_CH-1:0]         run_vec,
    input logic [NUM_CH*PHASE_W-1:0] phase_flat,
    input logic [NUM_CH-1:0]         pwm_out
);
    p_reset_low_r1: assert property (@(posedge clk) rst |=> (pwm_out == '0));

    for (genvar k = 0; k < NUM_CH; k++) begin : g_chk
        p_disabled_low_r5: assert property (@(posedge clk) disable iff (rst)
            !ch_en[k] |-> ##2 !pwm_out[k]);

        p_mode_gate_r6: assert property (@(posedge clk) disable iff (rst)
            (mode_sel != NORMAL_MODE) |-> ##2 !pwm_out[k]);

        p_idle_phase_r5: assert property (@(posedge clk) disable iff (rst)
            !run_vec[k] |=> (phase_flat[PHASE_W*k +: PHASE_W] == '0));

        p_hold_no_tick_r10: assert property (@(posedge clk) disable iff (rst)
            (!tick && run_vec[k] && ch_en[k] && mode_sel == NORMAL_MODE)
            |=> $stable(phase_flat[PHASE_W*k +: PHASE_W]));

        p_full_duty_r3: assert property (@(posedge clk) disable iff (rst)
            (run_vec[k] && duty_code[8*k +: 8] == 8'hFF && !pol_inv[k]) |=> pwm_out[k]);

        p_full_duty_inv_r4: assert property (@(posedge clk) disable iff (rst)
            (run_vec[k] && duty_code[8*k +: 8] == 8'hFF && pol_inv[k]) |=> !pwm_out[k]);
    end
endmodule

bind quad_step_pwm quad_step_pwm_chk #(
    .NUM_CH(NUM_CH), .PHASE_W(PHASE_W), .NORMAL_MODE(NORMAL_MODE)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .mode_sel   (mode_sel),
    .duty_code  (duty_code),
    .pol_inv    (pol_inv),
    .ch_en      (ch_en),
    .tick       (tick_w),
    .run_vec    (run_vec),
    .phase_flat (phase_flat),
    .pwm_out    (pwm_out)
);

// File: tb/test_quad_step_pwm.sv
module test_quad_step_pwm;
    localparam int NCH  = 4;
    localparam int PW   = 14;
    localparam int TDIV = 3;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [1:0]      mode_sel = 2'b00;
    logic [8*NCH-1:0] freq_code = '0;
    logic [8*NCH-1:0] duty_code = '0;
    logic [NCH-1:0]  pol_inv = '0;
    logic [NCH-1:0]  ch_en = '0;
    logic [NCH-1:0]  pwm_out;

    int tests = 0;
    int fails = 0;
    string cur_tag = "R1";

    logic [NCH-1:0] exp_q[$];
    string          tag_q[$];

    // model state
    int unsigned ref_ph[NCH];
    bit          ref_on[NCH];
    int          ref_tc;

    always #10 clk = ~clk;

    quad_step_pwm #(.NUM_CH(NCH), .PHASE_W(PW), .TICK_DIV(TDIV), .NORMAL_MODE(2'b01)) i_quad_step_pwm (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .freq_code(freq_code),
        .duty_code(duty_code), .pol_inv(pol_inv), .ch_en(ch_en), .pwm_out(pwm_out)
    );

    // driver side: reference of R2..R10 pushes the expected output per edge
    always @(posedge clk) begin
        logic [NCH-1:0] e;
        bit t;
        e = '0;
        if (rst) begin
            for (int i = 0; i < NCH; i++) begin ref_ph[i] = 0; ref_on[i] = 0; end
            ref_tc = 0;
        end else begin
            for (int i = 0; i < NCH; i++) begin
                int unsigned top;
                top = (ref_ph[i] >> (PW - 8)) & 255;
                if (ref_on[i])
                    e[i] = (top <= duty_code[8*i +: 8]) ^ pol_inv[i];
            end
            t = (ref_tc == TDIV - 1);
            ref_tc = t ? 0 : ref_tc + 1;
            for (int i = 0; i < NCH; i++) begin
                int unsigned inc;
                inc = (int'(freq_code[8*i +: 6]) + 1) << (2 * int'(freq_code[8*i+6 +: 2]));
                if (!ref_on[i]) ref_ph[i] = 0;
                else if (t) ref_ph[i] = (ref_ph[i] + inc) % (1 << PW);
                ref_on[i] = ch_en[i] && (mode_sel == 2'b01);
            end
        end
        exp_q.push_back(e);
        tag_q.push_back(cur_tag);
    end

    // monitor: compare away from the active edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [NCH-1:0] e;
            string tg;
            e  = exp_q.pop_front();
            tg = tag_q.pop_front();
            tests++;
            if (pwm_out !== e) begin
                fails++;
                $display("FAIL %s: pwm_out=%b expected=%b at %0t", tg, pwm_out, e, $time);
            end
        end
    end

    task automatic run(input int n, input string tag);
        cur_tag = tag;
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] fc(input int step, input int cnt);
        return {step[1:0], cnt[5:0]};
    endfunction

    task automatic direct_check(input logic got, input logic exp, input string tag);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got=%b expected=%b", tag, got, exp);
        end
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog: got=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        run(5, "R1_reset");
        direct_check(pwm_out == '0, 1'b1, "R1 outputs low in reset");
        rst = 1'b0;

        // R6: enabled but mode not normal
        ch_en = '1; duty_code = {4{8'hFF}};
        run(60, "R6_mode_off");
        direct_check(pwm_out == '0, 1'b1, "R6 low while mode off");
        mode_sel = 2'b10;
        run(30, "R6_mode_other");

        // R2 R3 R4 R8 R9 R10: distinct settings per channel
        freq_code = {fc(0, 0), fc(1, 20), fc(2, 5), fc(3, 63)};
        duty_code = {8'd0, 8'd255, 8'd64, 8'd127};
        pol_inv   = 4'b0010;
        mode_sel  = 2'b01;
        run(3, "R5_R8_start");
        direct_check(pwm_out[0], 1'b1, "R5 phase zero gives active start");
        run(1500, "R2_R3_R4_R9_R10_mixed");
        direct_check(pwm_out[2], 1'b1, "R3 duty 255 always high");
        direct_check(pwm_out[3], 1'b0, "R3 duty 0 low after 1/256");

        // R7: change settings mid-run on channel 0 without restart
        freq_code[7:0] = fc(2, 40);
        duty_code[7:0] = 8'd200;
        run(400, "R7_update_freq_duty");
        pol_inv[0] = 1'b1;
        run(200, "R7_update_polarity");

        // R5: disable an inverted channel, then re-enable
        ch_en[1] = 1'b0;
        run(100, "R5_disabled_inverted");
        direct_check(pwm_out[1], 1'b0, "R5 disabled inverted low");
        ch_en[1] = 1'b1;
        run(300, "R5_reenable");

        // R4: inverted full duty stays low
        pol_inv[2] = 1'b1;
        run(100, "R4_invert_full");
        direct_check(pwm_out[2], 1'b0, "R4 inverted duty 255 low");

        // R6: leave normal mode during run
        mode_sel = 2'b11;
        run(50, "R6_mode_exit");
        direct_check(pwm_out == '0, 1'b1, "R6 all low after mode exit");
        mode_sel = 2'b01;
        run(400, "R6_R5_resume");

        // R1: reset mid-run
        rst = 1'b1;
        run(4, "R1_reset_mid");
        direct_check(pwm_out == '0, 1'b1, "R1 low in mid-run reset");
        rst = 1'b0;
        run(200, "R1_after_reset");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule